// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a bus-programmed watchdog. A 32-bit down-counter is clocked by a count-enable strobe and starts from a programmable reload value. The first time the count runs out, the block reloads the counter and raises an interrupt. If software has not cleared that interrupt by the time the count runs out again, and the reset path is enabled, the block drives a system reset request. The reset request stays high until the block itself is reset.

Software services the watchdog by writing to a clear register. That write drops the pending interrupt and restarts the count from the reload value. A key-protected lock guards the reload, control and clear registers against stray writes. Raw and masked status bits show the interrupt state. The bus carries one access per cycle. A write is taken on the clock edge, and read data follows the address combinationally in the same cycle.

Top module: `dual_expiry_wdog`

## Requirements
- R1: After reset the lock register (0xC00) reads 1, control (0x008) reads 0, the reload value (0x000) and the current count (0x004) read 0xFFFFFFFF, and irqOut and rstOut are low.
- R2: Writing 0x1ACCE551 to 0xC00 unlocks the block, and 0xC00 then reads 0. Writing any other value to 0xC00 locks it, and 0xC00 then reads 1. Lock writes are accepted in either state.
- R3: While the block is locked, writes to 0x000, 0x008 and 0x00C have no effect.
- R4: In the control register at 0x008, bit 0 enables counting and the interrupt, and bit 1 enables the reset output. Reads return these two bits, and all higher bits read as 0.
- R5: An unlocked write to 0x000 sets the reload value and also loads the counter with that value at once.
- R6: While control bit 0 is set, the counter drops by one on every clock edge at which tickEn is high. It holds its value when tickEn is low or when bit 0 is clear.
- R7: A tick that arrives while the count is 0 is an expiry. The counter reloads from the reload value, and if no interrupt is pending, the pending bit (0x010 bit 0) is set.
- R8: An expiry that finds the interrupt already pending asserts rstOut when control bit 1 is set. When bit 1 is clear, rstOut stays low and the counter simply reloads.
- R9: Once rstOut is high, it stays high until rstN is asserted, whatever is written on the bus.
- R10: irqOut and bit 0 of the masked status register at 0x014 both equal the pending bit ANDed with control bit 0.
- R11: Any unlocked write to 0x00C clears the pending interrupt and reloads the counter from the reload value.
- R12: If an unlocked write to 0x000 or 0x00C lands on the same edge as a tick, the write wins and that tick is discarded.
- R13: With a reload value of 0 and both control bits set, the first tick raises the interrupt and the second tick asserts rstOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Register byte address |
| busWrEn | input | 1 | Write strobe, taken on the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, valid in the same cycle |
| tickEn | input | 1 | Count-enable strobe, one count per high cycle |
| irqOut | output | 1 | Masked interrupt |
| rstOut | output | 1 | Sticky system reset request |

## Verification
The assertions assume that busAddr and busWrEn are stable around each rising edge and that tickEn is a clean one-cycle-per-count strobe. They also treat the lock state and the control bits seen at an edge as the values that govern that edge. The stimulus changes every input only on falling edges. Each bus write and each tick burst spans whole cycles, so every edge sees a single settled command. The collision case is produced on purpose, by raising a tick and a clear write on the same falling edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int unsigned WDOG_DW = 32;
  parameter int unsigned WDOG_AW = 12;

  localparam logic [WDOG_AW-1:0] OFS_RELOAD = 12'h000;
  localparam logic [WDOG_AW-1:0] OFS_COUNT  = 12'h004;
  localparam logic [WDOG_AW-1:0] OFS_CTRL   = 12'h008;
  localparam logic [WDOG_AW-1:0] OFS_CLEAR  = 12'h00C;
  localparam logic [WDOG_AW-1:0] OFS_RAW    = 12'h010;
  localparam logic [WDOG_AW-1:0] OFS_MASKED = 12'h014;
  localparam logic [WDOG_AW-1:0] OFS_LOCK   = 12'hC00;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic               reloadWr;
    logic               clearWr;
    logic               countOn;
    logic               resetOn;
    logic [WDOG_DW-1:0] wrData;
  } wdog_strobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter logic [WDOG_DW-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WDOG_AW-1:0] busAddr,
  input  logic               busWrEn,
  input  logic [WDOG_DW-1:0] busWrData,
  input  logic [WDOG_DW-1:0] reloadVal,
  input  logic [WDOG_DW-1:0] countVal,
  input  logic               irqPend,
  output logic [WDOG_DW-1:0] busRdData,
  output logic               lockedQ,
  output wdog_strobe_t       strobe
);
  localparam int unsigned CTRL_W = 2;

  logic [CTRL_W-1:0] ctrlQ;
  logic              wrOpen;

  assign wrOpen = busWrEn && !lockedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockedQ <= 1'b1;
      ctrlQ   <= '0;
    end else begin
      if (busWrEn && busAddr == OFS_LOCK)
        lockedQ <= (busWrData != UNLOCK_KEY);
      if (wrOpen && busAddr == OFS_CTRL)
        ctrlQ <= busWrData[CTRL_W-1:0];
    end
  end

  always_comb begin
    strobe.reloadWr = wrOpen && busAddr == OFS_RELOAD;
    strobe.clearWr  = wrOpen && busAddr == OFS_CLEAR;
    strobe.countOn  = ctrlQ[0];
    strobe.resetOn  = ctrlQ[1];
    strobe.wrData   = busWrData;
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      OFS_RELOAD: busRdData = reloadVal;
      OFS_COUNT:  busRdData = countVal;
      OFS_CTRL:   busRdData[CTRL_W-1:0] = ctrlQ;
      OFS_RAW:    busRdData[0] = irqPend;
      OFS_MASKED: busRdData[0] = irqPend & ctrlQ[0];
      OFS_LOCK:   busRdData[0] = lockedQ;
      default:    busRdData = '0;
    endcase
  end
endmodule

// File: rtl/wdog_count_path.sv
module wdog_count_path
  import wdog_pkg::*;
#(
  parameter logic [WDOG_DW-1:0] RELOAD_INIT = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  wdog_strobe_t       strobe,
  output logic [WDOG_DW-1:0] reloadVal,
  output logic [WDOG_DW-1:0] countVal,
  output logic               irqPend,
  output logic               rstReq
);
  logic busOwns;
  logic expiry;

  assign busOwns = strobe.reloadWr || strobe.clearWr;
  assign expiry  = !busOwns && strobe.countOn && tickEn && (countVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= RELOAD_INIT;
      countVal  <= RELOAD_INIT;
    end else if (strobe.reloadWr) begin
      reloadVal <= strobe.wrData;
      countVal  <= strobe.wrData;
    end else if (strobe.clearWr || expiry) begin
      countVal <= reloadVal;
    end else if (strobe.countOn && tickEn) begin
      countVal <= countVal - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      if (strobe.clearWr)
        irqPend <= 1'b0;
      else if (expiry)
        irqPend <= 1'b1;
      if (expiry && irqPend && strobe.resetOn)
        rstReq <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_expiry_wdog.sv
module dual_expiry_wdog
  import wdog_pkg::*;
#(
  parameter logic [WDOG_DW-1:0] UNLOCK_KEY  = 32'h1ACCE551,
  parameter logic [WDOG_DW-1:0] RELOAD_INIT = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WDOG_AW-1:0] busAddr,
  input  logic               busWrEn,
  input  logic [WDOG_DW-1:0] busWrData,
  output logic [WDOG_DW-1:0] busRdData,
  input  logic               tickEn,
  output logic               irqOut,
  output logic               rstOut
);
  wdog_strobe_t       strobe;
  logic [WDOG_DW-1:0] reloadVal;
  logic [WDOG_DW-1:0] countVal;
  logic               irqPend;
  logic               lockedQ;
  logic               ctrlIe;
  logic               ctrlRe;

  wdog_ctrl #(.UNLOCK_KEY(UNLOCK_KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .reloadVal(reloadVal), .countVal(countVal),
    .irqPend(irqPend), .busRdData(busRdData), .lockedQ(lockedQ),
    .strobe(strobe)
  );

  wdog_count_path #(.RELOAD_INIT(RELOAD_INIT)) u_path (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .reloadVal(reloadVal), .countVal(countVal), .irqPend(irqPend),
    .rstReq(rstOut)
  );

  assign ctrlIe = strobe.countOn;
  assign ctrlRe = strobe.resetOn;
  assign irqOut = irqPend & ctrlIe;
endmodule

// File: rtl/dual_expiry_wdog_chk.sv
module dual_expiry_wdog_chk
  import wdog_pkg::*;
#(
  parameter logic [WDOG_DW-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
  input logic               clk,
  input logic               rstN,
  input logic [WDOG_AW-1:0] busAddr,
  input logic               busWrEn,
  input logic [WDOG_DW-1:0] busWrData,
  input logic               tickEn,
  input logic               rstOut,
  input logic [WDOG_DW-1:0] reloadVal,
  input logic [WDOG_DW-1:0] countVal,
  input logic               irqPend,
  input logic               lockedQ,
  input logic               ctrlIe,
  input logic               ctrlRe
);
  logic countWrite;
  assign countWrite = busWrEn && !lockedQ &&
                      (busAddr == OFS_RELOAD || busAddr == OFS_CLEAR);

  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_LOCK && busWrData == UNLOCK_KEY) |=> !lockedQ);

  assert_locked_reload_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lockedQ && busWrEn && busAddr == OFS_RELOAD) |=> $stable(reloadVal));

  assert_locked_ctrl_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lockedQ && busWrEn && busAddr == OFS_CTRL) |=> ($stable(ctrlIe) && $stable(ctrlRe)));

  assert_count_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!countWrite && (!ctrlIe || !tickEn)) |=> $stable(countVal));

  assert_irq_from_expiry_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPend) |-> $past(tickEn && ctrlIe && countVal == '0));

  assert_reset_needs_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstOut) |-> $past(irqPend && ctrlRe));

  assert_reset_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstOut |=> rstOut);

  assert_clear_drops_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !lockedQ && busAddr == OFS_CLEAR) |=> !irqPend);
endmodule

bind dual_expiry_wdog dual_expiry_wdog_chk #(.UNLOCK_KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .tickEn(tickEn), .rstOut(rstOut),
  .reloadVal(reloadVal), .countVal(countVal), .irqPend(irqPend),
  .lockedQ(lockedQ), .ctrlIe(ctrlIe), .ctrlRe(ctrlRe)
);

// File: tb/dual_expiry_wdog_tb.sv
module dual_expiry_wdog_tb;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        tickEn = 1'b0;
  logic        irqOut;
  logic        rstOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_expiry_wdog u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tickEn(tickEn),
    .irqOut(irqOut), .rstOut(rstOut)
  );

  task automatic expect_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    expect_val(req, busRdData, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic test_reset_state();
    rd("R1 lock", 12'hC00, 32'h1);
    rd("R1 ctrl", 12'h008, 32'h0);
    rd("R1 reload", 12'h000, 32'hFFFFFFFF);
    rd("R1 count", 12'h004, 32'hFFFFFFFF);
    expect_val("R1 irqOut", {31'b0, irqOut}, 32'h0);
    expect_val("R1 rstOut", {31'b0, rstOut}, 32'h0);
  endtask

  task automatic test_lock();
    wr(12'hC00, KEY);
    rd("R2 unlocked", 12'hC00, 32'h0);
    wr(12'hC00, 32'h5);
    rd("R2 relocked", 12'hC00, 32'h1);
    wr(12'h000, 32'h55);
    wr(12'h008, 32'h3);
    rd("R3 reload ignored", 12'h000, 32'hFFFFFFFF);
    rd("R3 ctrl ignored", 12'h008, 32'h0);
    wr(12'hC00, KEY);
  endtask

  task automatic test_regs();
    wr(12'h000, 32'd10);
    rd("R5 reload", 12'h000, 32'd10);
    rd("R5 count", 12'h004, 32'd10);
    wr(12'h008, 32'h7);
    rd("R4 ctrl bits", 12'h008, 32'h3);
    wr(12'h008, 32'h1);
    rd("R4 ctrl bit0", 12'h008, 32'h1);
  endtask

  task automatic test_count();
    ticks(4);
    rd("R6 decrement", 12'h004, 32'd6);
    repeat (3) @(negedge clk);
    rd("R6 hold tick low", 12'h004, 32'd6);
    wr(12'h008, 32'h0);
    ticks(3);
    rd("R6 hold disabled", 12'h004, 32'd6);
  endtask

  task automatic test_expiry();
    wr(12'h000, 32'd3);
    wr(12'h008, 32'h1);
    ticks(3);
    rd("R7 at zero", 12'h004, 32'd0);
    rd("R7 not yet pending", 12'h010, 32'h0);
    ticks(1);
    rd("R7 reloaded", 12'h004, 32'd3);
    rd("R7 raw pending", 12'h010, 32'h1);
    rd("R10 masked", 12'h014, 32'h1);
    expect_val("R10 irqOut high", {31'b0, irqOut}, 32'h1);
    ticks(4);
    expect_val("R8 no reset when disabled", {31'b0, rstOut}, 32'h0);
    rd("R8 reloads again", 12'h004, 32'd3);
    wr(12'h008, 32'h0);
    rd("R10 masked off", 12'h014, 32'h0);
    expect_val("R10 irqOut low", {31'b0, irqOut}, 32'h0);
    rd("R10 raw kept", 12'h010, 32'h1);
    wr(12'hC00, 32'h1);
    wr(12'h00C, 32'h0);
    rd("R3 clear ignored", 12'h010, 32'h1);
    wr(12'hC00, KEY);
  endtask

  task automatic test_clear();
    wr(12'h008, 32'h1);
    ticks(2);
    rd("R11 count before", 12'h004, 32'd1);
    wr(12'h00C, 32'hDEAD);
    rd("R11 pending cleared", 12'h010, 32'h0);
    rd("R11 count reloaded", 12'h004, 32'd3);
  endtask

  task automatic test_collision();
    ticks(3);
    rd("R12 at zero", 12'h004, 32'd0);
    @(negedge clk);
    tickEn = 1'b1; busAddr = 12'h00C; busWrEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; busWrEn = 1'b0;
    rd("R12 clear wins count", 12'h004, 32'd3);
    rd("R12 no irq", 12'h010, 32'h0);
    @(negedge clk);
    tickEn = 1'b1; busAddr = 12'h000; busWrData = 32'd9; busWrEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; busWrEn = 1'b0;
    rd("R12 reload wins", 12'h004, 32'd9);
  endtask

  task automatic test_fast_reset();
    wr(12'h008, 32'h0);
    wr(12'h000, 32'h0);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h3);
    ticks(1);
    rd("R13 first tick irq", 12'h010, 32'h1);
    expect_val("R13 no reset yet", {31'b0, rstOut}, 32'h0);
    ticks(1);
    expect_val("R13 reset on second", {31'b0, rstOut}, 32'h1);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h0);
    repeat (2) @(negedge clk);
    expect_val("R9 reset sticky", {31'b0, rstOut}, 32'h1);
    do_reset();
    expect_val("R9 cleared by rstN", {31'b0, rstOut}, 32'h0);
    rd("R1 relocked after reset", 12'hC00, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset_state();
    test_lock();
    test_regs();
    test_count();
    test_expiry();
    test_clear();
    test_collision();
    test_fast_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule